// File: doc/BRIEF.md
# Pixel Block Framing Sync Generator

This block sits at the output of a decoder datapath and frames the stream of image samples that leaves it. Samples arrive on a valid/ready input with a last-of-scan flag. Each accepted sample comes out two clocks later on a registered data port. Two active-low strobes run beside the data. A block-start strobe goes low for one clock just before the first sample of a frame unit. An end-of-scan strobe goes low for one clock together with the final sample of a scan.

There are two framing modes. In block mode, samples are counted into 8x8 blocks of 64, and the start strobe marks sample positions 0, 64, 128 and so on within the scan. In per-sample mode, every sample gets its own start strobe. The start strobe is never given for the last sample of a scan; that sample carries only the end-of-scan strobe. The block counter goes back to zero after every scan, so a new scan always starts on a block boundary.

Back-pressure rules: the upstream may hold `in_valid` high for as long as it likes, and a sample moves only on a clock where `in_valid` and `in_ready` are both high. In block mode `in_ready` stays high outside reset. In per-sample mode `in_ready` drops for the one clock after each accepted sample, so that adjacent start strobes stay separate one-clock pulses. The output side has no ready input, because the strobes keep a fixed timing relation to the data.

Top module: `pixsync_framer`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `blk_start_n` and `eos_n` are 1, `out_valid` is 0 and `in_ready` is 0 (`in_ready` is 0 only while `rst` is high).
- R2: A sample accepted at clock edge k appears on `out_data`, with `out_valid` high, for exactly the cycle after edge k+1. Samples leave in the order they were accepted.
- R3: In block mode (`mode_per_sample`=0), `blk_start_n` is low for the cycle after edge k when the sample accepted at edge k has a position within its scan (counting from 0) that is a multiple of 64, and that sample is not the last of the scan.
- R4: Every low pulse on `blk_start_n` lasts one cycle and is followed in the next cycle by `out_valid` high, so the strobe leads its sample by exactly one clock.
- R5: In per-sample mode (`mode_per_sample`=1), every accepted sample that is not last of scan produces a `blk_start_n` low pulse in the cycle after its acceptance.
- R6: In per-sample mode, `in_ready` is 0 in the cycle after any accepted sample. In block mode, `in_ready` is 1 whenever `rst` is 0 and no per-sample acceptance happened at the previous edge.
- R7: `eos_n` is low, for one cycle, exactly in the cycle in which `out_valid` presents a sample that was accepted with `in_last`=1.
- R8: A sample accepted with `in_last`=1 never produces a `blk_start_n` pulse, even at position 0 or at a multiple of 64.
- R9: After a sample with `in_last`=1, the position count returns to 0, so the next accepted sample in block mode produces a start strobe unless it is itself last.
- R10: Clocks with `in_valid`=0 move no sample: they produce no `out_valid`, no strobe and no change in the position count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_per_sample | input | 1 | 0 = 64-sample block framing, 1 = strobe every sample |
| in_valid | input | 1 | Upstream sample valid |
| in_ready | output | 1 | Block can take a sample this clock |
| in_data | input | DATA_W (8) | Sample value |
| in_last | input | 1 | Sample is the last of its scan |
| out_valid | output | 1 | `out_data` holds a sample this cycle |
| out_data | output | DATA_W (8) | Registered sample value |
| blk_start_n | output | 1 | Active-low start strobe, one clock ahead of its sample |
| eos_n | output | 1 | Active-low end-of-scan strobe, aligned with the last sample |

## Verification
Block mode is driven with scans of 130, 64, 65 and 1 samples. These lengths separate correct wrap at 64 from an off-by-one in the counter. They also separate strobe suppression on a last sample that falls on a block boundary from suppression that never happens. Random idle gaps in `in_valid` show that the position count advances only on accepted samples. Per-sample scans, with the upstream holding `in_valid` high, test the one-clock ready gap and the per-sample strobes. Mode changes between scans show that the count restarts at each scan.

// File: rtl/pixsync_pkg.sv
package pixsync_pkg;
  localparam int unsigned SAMPLES_PER_BLOCK = 64;

  typedef enum logic {
    FRAME_BLOCK  = 1'b0,
    FRAME_SAMPLE = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/pixsync_gate.sv
module pixsync_gate (
  input  logic clk,
  input  logic rst,
  input  logic mode_per_sample,
  input  logic in_valid,
  output logic in_ready,
  output logic fire
);
  import pixsync_pkg::*;

  logic gap_q;

  assign in_ready = ~rst & ~gap_q;
  assign fire     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) gap_q <= 1'b0;
    else     gap_q <= fire & (frame_mode_e'(mode_per_sample) == FRAME_SAMPLE);
  end

  // R6: after a per-sample acceptance the next clock refuses input
  a_r6_sample_gap: assert property (@(posedge clk) disable iff (rst)
    (fire && mode_per_sample) |=> !in_ready);
endmodule

// File: rtl/pixsync_count.sv
module pixsync_count #(
  parameter int unsigned BLK_LEN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_per_sample,
  input  logic fire,
  input  logic last,
  output logic first_pos
);
  localparam int unsigned CNT_W = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(BLK_LEN - 1);

  logic [CNT_W-1:0] pos_q;

  assign first_pos = mode_per_sample | (pos_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (fire) begin
      if (last || mode_per_sample) pos_q <= '0;
      else if (pos_q == LAST_POS)  pos_q <= '0;
      else                         pos_q <= pos_q + 1'b1;
    end
  end

  // R9: the position count restarts after the last sample of a scan
  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    (fire && last) |=> (pos_q == '0));
  // R10: idle clocks keep the count
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!fire) |=> $stable(pos_q));
endmodule

// File: rtl/pixsync_pipe.sv
module pixsync_pipe #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              first_pos,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              blk_start_n,
  output logic              eos_n
);
  logic              s1_valid;
  logic              s1_last;
  logic [DATA_W-1:0] s1_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid    <= 1'b0;
      s1_last     <= 1'b0;
      s1_data     <= '0;
      blk_start_n <= 1'b1;
    end else begin
      s1_valid    <= fire;
      s1_last     <= fire & in_last;
      if (fire) s1_data <= in_data;
      blk_start_n <= ~(fire & first_pos & ~in_last);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      eos_n     <= 1'b1;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= s1_data;
      eos_n     <= ~(s1_valid & s1_last);
    end
  end

  // R4: a start strobe is followed by its sample one clock later
  a_r4_strobe_leads: assert property (@(posedge clk) disable iff (rst)
    (!blk_start_n) |=> out_valid);
  // R7: end-of-scan only rides on a presented sample
  a_r7_eos_with_data: assert property (@(posedge clk) disable iff (rst)
    (!eos_n) |-> out_valid);
endmodule

// File: rtl/pixsync_framer.sv
module pixsync_framer #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned BLK_LEN = pixsync_pkg::SAMPLES_PER_BLOCK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_per_sample,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              blk_start_n,
  output logic              eos_n
);
  logic fire;
  logic first_pos;

  pixsync_gate u_gate (
    .clk             (clk),
    .rst             (rst),
    .mode_per_sample (mode_per_sample),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .fire            (fire)
  );

  pixsync_count #(.BLK_LEN(BLK_LEN)) u_count (
    .clk             (clk),
    .rst             (rst),
    .mode_per_sample (mode_per_sample),
    .fire            (fire),
    .last            (in_last),
    .first_pos       (first_pos)
  );

  pixsync_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk         (clk),
    .rst         (rst),
    .fire        (fire),
    .in_data     (in_data),
    .in_last     (in_last),
    .first_pos   (first_pos),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .blk_start_n (blk_start_n),
    .eos_n       (eos_n)
  );

  // R8: a last-of-scan sample never gets a start strobe
  a_r8_no_strobe_on_last: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> blk_start_n);
  // R2: an accepted sample is presented two clocks later
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 out_valid);
endmodule

// File: tb/sim_pixsync_framer.sv
`timescale 1ns/1ps
module sim_pixsync_framer;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_per_sample = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_ready, out_valid, blk_start_n, eos_n;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pixsync_framer u0 (
    .clk(clk), .rst(rst), .mode_per_sample(mode_per_sample),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_data(out_data),
    .blk_start_n(blk_start_n), .eos_n(eos_n)
  );

  // behavioural reference model
  bit m_gap, m_strb, m_acc;
  bit m_v1, m_l1, m_v2, m_l2;
  logic [DW-1:0] m_d1, m_d2;
  int m_idx;
  int strobe_cnt = 0;
  int eos_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_gap = 0; m_strb = 0; m_acc = 0; m_idx = 0;
      m_v1 = 0; m_l1 = 0; m_v2 = 0; m_l2 = 0; m_d1 = '0; m_d2 = '0;
    end else begin
      bit f;
      f = in_valid && !m_gap;
      m_v2 = m_v1; m_d2 = m_d1; m_l2 = m_l1;
      m_v1 = f; m_d1 = in_data; m_l1 = f && in_last;
      m_strb = f && (mode_per_sample || (m_idx % 64 == 0)) && !in_last;
      if (f) m_idx = (in_last || mode_per_sample) ? 0 : m_idx + 1;
      m_gap = f && mode_per_sample;
      m_acc = f;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(in_ready == !m_gap, "R6 in_ready", in_ready, !m_gap);
      chk(blk_start_n == !m_strb, "R3 R5 R8 R9 blk_start_n", blk_start_n, !m_strb);
      chk(out_valid == m_v2, "R2 R4 R10 out_valid", out_valid, m_v2);
      chk(eos_n == !(m_v2 && m_l2), "R7 eos_n", eos_n, !(m_v2 && m_l2));
      if (m_v2) chk(out_data == m_d2, "R2 out_data", out_data, m_d2);
      if (!blk_start_n) strobe_cnt++;
      if (!eos_n) eos_cnt++;
    end
  end

  task automatic send(input logic [DW-1:0] d, input bit last, input bit gaps);
    if (gaps && ($urandom_range(0, 3) == 0)) begin
      @(negedge clk); in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last;
    forever begin
      @(posedge clk); #1;
      if (m_acc) break;
    end
  endtask

  task automatic scan(input bit per_sample, input int len, input bit gaps);
    @(negedge clk);
    in_valid = 1'b0;
    mode_per_sample = per_sample;
    for (int i = 0; i < len; i++) send(DW'(i * 7 + len), i == len - 1, gaps);
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic block_scan(input int len, input int exp_strobes, input bit gaps);
    int s0, e0;
    s0 = strobe_cnt; e0 = eos_cnt;
    scan(1'b0, len, gaps);
    chk(strobe_cnt - s0 == exp_strobes, "R3 R8 strobe count", strobe_cnt - s0, exp_strobes);
    chk(eos_cnt - e0 == 1, "R7 eos count", eos_cnt - e0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(blk_start_n && eos_n && !out_valid && !in_ready, "R1 reset state",
        {blk_start_n, eos_n, out_valid, in_ready}, 4'b1100);
    rst = 1'b0;
    @(negedge clk);
    chk(blk_start_n && eos_n && !out_valid && in_ready, "R1 after reset",
        {blk_start_n, eos_n, out_valid, in_ready}, 4'b1101);
    repeat (5) @(negedge clk);
    chk(blk_start_n && !out_valid, "R10 idle", {blk_start_n, out_valid}, 2'b10);
    block_scan(130, 3, 1'b0);
    block_scan(64, 1, 1'b1);
    block_scan(65, 1, 1'b0);   // position 64 is last: R8 suppresses it
    block_scan(1, 0, 1'b0);
    begin
      int s0;
      s0 = strobe_cnt;
      scan(1'b1, 10, 1'b0);
      chk(strobe_cnt - s0 == 9, "R5 per-sample strobes", strobe_cnt - s0, 9);
    end
    block_scan(70, 2, 1'b1);   // R9 restart after mode change
    scan(1'b1, 5, 1'b1);
    block_scan(128, 2, 1'b1);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule